// File: doc/BRIEF.md
# Two-Stage Instruction Fetch Sequencer

This block is the program sequencer of a small 8-bit core whose program bus and data bus are separate. It holds a 16-bit fetch address. In every cycle it reads one complete 16-bit instruction word over the program bus. At the same time it presents the word it fetched in the previous cycle to the execute stage. Fetch of the next word therefore overlaps execution of the current one.

The execute stage steers the sequencer in three ways:
- A branch request with a target address.
- A stall, used while a multi-cycle instruction such as a table transfer is still busy.
- A write on the data bus. The fetch address is mapped into the data address space as a low-byte register and a high-byte holding register, so a data write to the low byte acts as a jump.

Any redirect discards the word already fetched, which costs one bubble cycle. A two-bit execution mode decides where each fetch goes. The internal-only modes use the on-chip program array, external-only mode uses the external program bus, and mixed mode splits the address space at the size of the internal array.

Top module: `prog_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next state is: fetch address 0000h, `ex_valid_o` = 0 and `ex_instr_o` = 0000h (the no-operation word), and the high-byte holding register is cleared. During reset neither read strobe is asserted.
- R2: In a cycle with no stall, no branch and no write to the low-byte address, the following happens at the clock edge:
  - the fetch address advances by one, wrapping from FFFFh to 0000h;
  - `ex_instr_o` takes the word read at the old fetch address;
  - `ex_pc_o` takes that old address;
  - `ex_valid_o` becomes 1.
- R3: When `branch_i` is 1 at a clock edge, the fetch address becomes `branch_tgt_i`. The prefetched word is replaced by the no-operation word with `ex_valid_o` = 0, which is one bubble cycle.
- R4: A data write (`dwr_en_i` = 1) behaves according to its address:
  - To address 02h it loads the fetch address with {high-byte holding register, `dwr_data_i`} and flushes the slot as in R3.
  - To address 03h it only loads the holding register. It causes no redirect.
  - To any other address it has no effect.
- R5: When a branch and a write to 02h arrive in the same cycle, the branch target wins.
- R6: While `stall_i` = 1 and no redirect is present, the following holds:
  - the fetch address and the execute slot keep their values;
  - neither read strobe is asserted.
  A redirect in a stall cycle still takes effect.
- R7: In modes 00 (internal) and 01 (internal, protected), every fetch uses the internal bus. `int_addr_o` is the low `INT_AW` bits of the fetch address, and `ext_rd_o` stays 0.
- R8: In mode 10 (external), every fetch uses the external bus with `ext_addr_o` equal to the fetch address, and `int_rd_o` stays 0.
- R9: In mode 11 (mixed), fetch addresses below 2^`INT_AW` go to the internal bus and addresses at or above it go to the external bus.
- R10: At most one read strobe is asserted in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Execution mode: 00 internal, 01 internal protected, 10 external, 11 mixed |
| stall_i | input | 1 | Hold fetch and execute slot |
| branch_i | input | 1 | Branch request from execute |
| branch_tgt_i | input | PC_W | Branch target address |
| dwr_en_i | input | 1 | Data-bus write strobe |
| dwr_addr_i | input | DA_W | Data-bus write address |
| dwr_data_i | input | DW | Data-bus write data |
| int_rd_o | output | 1 | Internal program read strobe |
| int_addr_o | output | INT_AW | Internal program address |
| int_data_i | input | IW | Internal program read word (same cycle) |
| ext_rd_o | output | 1 | External program read strobe |
| ext_addr_o | output | PC_W | External program address |
| ext_data_i | input | IW | External program read word (same cycle) |
| pc_o | output | PC_W | Current fetch address |
| ex_valid_o | output | 1 | Execute slot holds a real instruction |
| ex_instr_o | output | IW | Instruction word in the execute slot |
| ex_pc_o | output | PC_W | Address of the word in the execute slot |

## Verification
The situations hardest to reach from the ports are two:
- collisions between control inputs: a branch arriving together with a low-byte write, or a redirect arriving in a stall cycle;
- the mixed-mode switch from the internal to the external bus exactly at 2^`INT_AW`.

The stimulus reaches the collisions by driving both inputs in the same cycle. It reaches the boundary by branching to two words below the boundary in mixed mode and letting sequential fetch cross it. A branch to FFFEh exercises the wrap to 0000h. A high-byte write followed some cycles later by a low-byte write proves that the holding register kept its value and produced no redirect of its own.

// File: rtl/prog_seq_pkg.sv
// Package: shared constants and types for the fetch sequencer.
// Assumes: a two-bit mode code at the top port.
package prog_seq_pkg;

    typedef enum logic [1:0] {
        MODE_INT      = 2'b00,
        MODE_INT_PROT = 2'b01,
        MODE_EXT      = 2'b10,
        MODE_MIXED    = 2'b11
    } exec_mode_e;

endpackage

// File: rtl/seq_pc_unit.sv
// Module: seq_pc_unit
// Holds the fetch address and the high-byte holding register that the
// data bus sees. Priority of next address: branch, low-byte write, advance.
// Assumes: PC_W > DW, and the data bus writes one DW-bit byte per cycle.
module seq_pc_unit #(
    parameter int PC_W     = 16,
    parameter int DW       = 8,
    parameter int DA_W     = 8,
    parameter logic [DA_W-1:0] PCL_ADDR = 8'h02,
    parameter logic [DA_W-1:0] PCH_ADDR = 8'h03
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            advance_i,
    input  logic            branch_i,
    input  logic [PC_W-1:0] branch_tgt_i,
    input  logic            dwr_en_i,
    input  logic [DA_W-1:0] dwr_addr_i,
    input  logic [DW-1:0]   dwr_data_i,
    output logic [PC_W-1:0] pc_q,
    output logic [PC_W-DW-1:0] pch_q,
    output logic            redirect_o
);
    localparam int HI_W = PC_W - DW;

    logic pcl_hit;
    logic pch_hit;

    // Decode data-bus writes aimed at the two mapped address bytes.
    always_comb begin
        pcl_hit    = dwr_en_i && (dwr_addr_i == PCL_ADDR);
        pch_hit    = dwr_en_i && (dwr_addr_i == PCH_ADDR);
        redirect_o = branch_i || pcl_hit;
    end

    // Next fetch address: branch beats low-byte write beats sequential step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc_q <= '0;
        else if (branch_i)
            pc_q <= branch_tgt_i;
        else if (pcl_hit)
            pc_q <= {pch_q, dwr_data_i};
        else if (advance_i)
            pc_q <= pc_q + 1'b1;
    end

    // High-byte holding register, written only through the data bus.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pch_q <= '0;
        else if (pch_hit)
            pch_q <= dwr_data_i[HI_W-1:0];
    end

endmodule

// File: rtl/seq_bus_sel.sv
// Module: seq_bus_sel
// Chooses internal or external program bus for the current fetch address
// from the execution mode. Purely combinational.
// Assumes: INT_AW <= PC_W; reads are enabled by fetch_en_i.
module seq_bus_sel
    import prog_seq_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int INT_AW = 13
) (
    input  exec_mode_e        mode_i,
    input  logic              fetch_en_i,
    input  logic [PC_W-1:0]   pc_i,
    output logic              int_rd_o,
    output logic              ext_rd_o,
    output logic [INT_AW-1:0] int_addr_o,
    output logic [PC_W-1:0]   ext_addr_o,
    output logic              use_ext_o
);
    logic below_int;

    // Internal window test; whole space is internal if the array covers it.
    generate
        if (INT_AW >= PC_W) begin : g_full_int
            assign below_int = 1'b1;
        end else begin : g_split
            assign below_int = ~|pc_i[PC_W-1:INT_AW];
        end
    endgenerate

    // Mode map and strobe generation.
    always_comb begin
        unique case (mode_i)
            MODE_INT, MODE_INT_PROT: use_ext_o = 1'b0;
            MODE_EXT:                use_ext_o = 1'b1;
            default:                 use_ext_o = !below_int;
        endcase
        int_rd_o   = fetch_en_i && !use_ext_o;
        ext_rd_o   = fetch_en_i && use_ext_o;
        int_addr_o = INT_AW'(pc_i);
        ext_addr_o = pc_i;
    end

endmodule

// File: rtl/seq_fetch_slot.sv
// Module: seq_fetch_slot
// The fetch-to-execute pipeline register: instruction word, its address
// and a valid flag. A flush loads the no-operation word (all zeros).
// Assumes: flush has priority over load; neither means hold.
module seq_fetch_slot #(
    parameter int IW   = 16,
    parameter int PC_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic            flush_i,
    input  logic [IW-1:0]   word_i,
    input  logic [PC_W-1:0] pc_i,
    output logic [IW-1:0]   instr_q,
    output logic [PC_W-1:0] ipc_q,
    output logic            valid_q
);
    // Pipeline slot update: flush to bubble, load fetched word, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            instr_q <= '0;
            ipc_q   <= '0;
            valid_q <= 1'b0;
        end else if (flush_i) begin
            instr_q <= '0;
            valid_q <= 1'b0;
        end else if (load_i) begin
            instr_q <= word_i;
            ipc_q   <= pc_i;
            valid_q <= 1'b1;
        end
    end

endmodule

// File: rtl/prog_seq.sv
// Module: prog_seq (top)
// Two-stage fetch/execute sequencer: fetches one IW-bit word per cycle
// while the previous word sits in the execute slot; handles branch,
// data-bus writes to the mapped fetch address, stalls and bus selection.
// Assumes: program memories answer combinationally in the same cycle.
module prog_seq
    import prog_seq_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int IW     = 16,
    parameter int DW     = 8,
    parameter int DA_W   = 8,
    parameter int INT_AW = 13,
    parameter logic [DA_W-1:0] PCL_ADDR = 8'h02,
    parameter logic [DA_W-1:0] PCH_ADDR = 8'h03
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              stall_i,
    input  logic              branch_i,
    input  logic [PC_W-1:0]   branch_tgt_i,
    input  logic              dwr_en_i,
    input  logic [DA_W-1:0]   dwr_addr_i,
    input  logic [DW-1:0]     dwr_data_i,
    output logic              int_rd_o,
    output logic [INT_AW-1:0] int_addr_o,
    input  logic [IW-1:0]     int_data_i,
    output logic              ext_rd_o,
    output logic [PC_W-1:0]   ext_addr_o,
    input  logic [IW-1:0]     ext_data_i,
    output logic [PC_W-1:0]   pc_o,
    output logic              ex_valid_o,
    output logic [IW-1:0]     ex_instr_o,
    output logic [PC_W-1:0]   ex_pc_o
);
    logic [PC_W-1:0]    pc_q;
    logic [PC_W-DW-1:0] pch_q;
    logic               redirect;
    logic               use_ext;
    logic               fetch_en;
    logic [IW-1:0]      fetched;

    // Reads happen whenever the pipeline moves and reset is released.
    always_comb begin
        fetch_en = rst_n && !stall_i;
        fetched  = use_ext ? ext_data_i : int_data_i;
        pc_o     = pc_q;
    end

    seq_pc_unit #(
        .PC_W(PC_W), .DW(DW), .DA_W(DA_W),
        .PCL_ADDR(PCL_ADDR), .PCH_ADDR(PCH_ADDR)
    ) u_pc (
        .clk(clk), .rst_n(rst_n), .advance_i(!stall_i),
        .branch_i(branch_i), .branch_tgt_i(branch_tgt_i),
        .dwr_en_i(dwr_en_i), .dwr_addr_i(dwr_addr_i), .dwr_data_i(dwr_data_i),
        .pc_q(pc_q), .pch_q(pch_q), .redirect_o(redirect)
    );

    seq_bus_sel #(.PC_W(PC_W), .INT_AW(INT_AW)) u_sel (
        .mode_i(exec_mode_e'(mode_i)), .fetch_en_i(fetch_en), .pc_i(pc_q),
        .int_rd_o(int_rd_o), .ext_rd_o(ext_rd_o),
        .int_addr_o(int_addr_o), .ext_addr_o(ext_addr_o), .use_ext_o(use_ext)
    );

    seq_fetch_slot #(.IW(IW), .PC_W(PC_W)) u_slot (
        .clk(clk), .rst_n(rst_n), .load_i(!stall_i), .flush_i(redirect),
        .word_i(fetched), .pc_i(pc_q),
        .instr_q(ex_instr_o), .ipc_q(ex_pc_o), .valid_q(ex_valid_o)
    );

endmodule

// File: rtl/prog_seq_chk.sv
// Module: prog_seq_chk
// Property checker for prog_seq, attached by bind below.
// Assumes: the parameters match those of the bound instance.
module prog_seq_chk #(
    parameter int PC_W   = 16,
    parameter int IW     = 16,
    parameter int DW     = 8,
    parameter int DA_W   = 8,
    parameter int INT_AW = 13,
    parameter logic [DA_W-1:0] PCL_ADDR = 8'h02
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode_i,
    input logic              stall_i,
    input logic              branch_i,
    input logic [PC_W-1:0]   branch_tgt_i,
    input logic              dwr_en_i,
    input logic [DA_W-1:0]   dwr_addr_i,
    input logic [DW-1:0]     dwr_data_i,
    input logic              int_rd_o,
    input logic              ext_rd_o,
    input logic [PC_W-1:0]   pc_o,
    input logic              ex_valid_o,
    input logic [IW-1:0]     ex_instr_o,
    input logic [PC_W-1:0]   ex_pc_o,
    input logic [PC_W-DW-1:0] pch_q
);
    localparam logic [PC_W:0] INT_LIMIT = (PC_W + 1)'(1) << INT_AW;

    logic low_wr;
    assign low_wr = dwr_en_i && (dwr_addr_i == PCL_ADDR);

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (pc_o == '0) && !ex_valid_o && (ex_instr_o == '0));

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_i && !branch_i && !low_wr) |=>
        (pc_o == PC_W'($past(pc_o) + 1'b1)) && ex_valid_o && (ex_pc_o == $past(pc_o)));

    assert_branch_bubble_R3: assert property (@(posedge clk) disable iff (!rst_n)
        branch_i |=> (pc_o == $past(branch_tgt_i)) && !ex_valid_o && (ex_instr_o == '0));

    assert_pcl_jump_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (low_wr && !branch_i) |=> (pc_o == {$past(pch_q), $past(dwr_data_i)}) && !ex_valid_o);

    assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_i && !branch_i && !low_wr) |=> $stable(pc_o) && $stable(ex_instr_o) && $stable(ex_valid_o));

    assert_stall_noread_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |-> !int_rd_o && !ext_rd_o);

    assert_int_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i[1] == 1'b0) |-> !ext_rd_o);

    assert_ext_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b10) |-> !int_rd_o);

    assert_mixed_split_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b11 && !stall_i) |-> (ext_rd_o == ({1'b0, pc_o} >= INT_LIMIT)));

    assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({int_rd_o, ext_rd_o}));

endmodule

bind prog_seq prog_seq_chk #(
    .PC_W(PC_W), .IW(IW), .DW(DW), .DA_W(DA_W), .INT_AW(INT_AW), .PCL_ADDR(PCL_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .stall_i(stall_i),
    .branch_i(branch_i), .branch_tgt_i(branch_tgt_i), .dwr_en_i(dwr_en_i),
    .dwr_addr_i(dwr_addr_i), .dwr_data_i(dwr_data_i), .int_rd_o(int_rd_o),
    .ext_rd_o(ext_rd_o), .pc_o(pc_o), .ex_valid_o(ex_valid_o),
    .ex_instr_o(ex_instr_o), .ex_pc_o(ex_pc_o), .pch_q(pch_q)
);

// File: tb/sim_prog_seq.sv
// Bench for prog_seq: behavioural reference model stepped once per clock.
module sim_prog_seq;
    localparam int CLK_PERIOD = 10;
    localparam int INT_AW     = 13;
    localparam int INT_WORDS  = 1 << INT_AW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        stall = 1'b0;
    logic        br = 1'b0;
    logic [15:0] tgt = '0;
    logic        we = 1'b0;
    logic [7:0]  wa = '0;
    logic [7:0]  wd = '0;
    logic        int_rd, ext_rd, ex_valid;
    logic [INT_AW-1:0] int_addr;
    logic [15:0] ext_addr, pc, ex_instr, ex_pc;
    logic [15:0] int_data, ext_data;

    // Program memories modelled as address functions, distinct per bus.
    assign int_data = {{(16-INT_AW){1'b0}}, int_addr} ^ 16'h1234;
    assign ext_data = ~ext_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    prog_seq u0 (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .stall_i(stall),
        .branch_i(br), .branch_tgt_i(tgt), .dwr_en_i(we), .dwr_addr_i(wa),
        .dwr_data_i(wd), .int_rd_o(int_rd), .int_addr_o(int_addr),
        .int_data_i(int_data), .ext_rd_o(ext_rd), .ext_addr_o(ext_addr),
        .ext_data_i(ext_data), .pc_o(pc), .ex_valid_o(ex_valid),
        .ex_instr_o(ex_instr), .ex_pc_o(ex_pc)
    );

    int checks = 0;
    int errors = 0;
    // Reference model state
    int m_pc = 0, m_instr = 0, m_ipc = 0, m_valid = 0, m_pch = 0;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic bit sel_ext(input int md, input int a);
        return (md == 2) || (md == 3 && a >= INT_WORDS);
    endfunction

    // One clock: drive at negedge, check strobes, advance model, check slot.
    task automatic step(input string tag, input int b, input int t, input int w,
                        input int adr, input int dat, input int st, input int md);
        int n_pc, n_instr, n_ipc, n_valid, word;
        bit ex;
        br = b[0]; tgt = t[15:0]; we = w[0]; wa = adr[7:0]; wd = dat[7:0];
        stall = st[0]; mode = md[1:0];
        #1;
        ex = sel_ext(md, m_pc);
        chk(tag, "int_rd", int_rd, (st == 0) && !ex);
        chk(tag, "ext_rd", ext_rd, (st == 0) && ex);
        if (st == 0 && ex)  chk(tag, "ext_addr", ext_addr, m_pc);
        if (st == 0 && !ex) chk(tag, "int_addr", int_addr, m_pc % INT_WORDS);
        word = ex ? ((~m_pc) & 16'hFFFF) : ((m_pc % INT_WORDS) ^ 16'h1234);
        n_pc = m_pc; n_instr = m_instr; n_ipc = m_ipc; n_valid = m_valid;
        if (b != 0) begin
            n_pc = t; n_instr = 0; n_valid = 0;
        end else if (w != 0 && adr == 2) begin
            n_pc = (m_pch << 8) | dat; n_instr = 0; n_valid = 0;
        end else if (st == 0) begin
            n_pc = (m_pc + 1) & 16'hFFFF; n_instr = word; n_ipc = m_pc; n_valid = 1;
        end
        if (w != 0 && adr == 3) m_pch = dat;
        @(negedge clk);
        m_pc = n_pc; m_instr = n_instr; m_ipc = n_ipc; m_valid = n_valid;
        chk(tag, "pc_o", pc, m_pc);
        chk(tag, "ex_valid_o", ex_valid, m_valid);
        chk(tag, "ex_instr_o", ex_instr, m_instr);
        if (m_valid != 0) chk(tag, "ex_pc_o", ex_pc, m_ipc);
    endtask

    task automatic run(input string tag, input int n, input int md);
        for (int i = 0; i < n; i++) step(tag, 0, 0, 0, 0, 0, 0, md);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state and no strobes while reset is held
        chk("R1", "pc_o", pc, 0);
        chk("R1", "ex_valid_o", ex_valid, 0);
        chk("R1", "ex_instr_o", ex_instr, 0);
        chk("R1", "rd strobes", {int_rd, ext_rd}, 0);
        rst_n = 1'b1;
        run("R2", 6, 0);                            // R2 sequential, internal
        run("R7", 3, 1);                            // R7 protected mode
        step("R3", 1, 16'h0040, 0, 0, 0, 0, 0);     // R3 branch bubble
        run("R3", 3, 0);
        step("R4", 0, 0, 1, 3, 8'h01, 0, 0);        // R4 high byte only
        run("R4", 2, 0);
        step("R4", 0, 0, 1, 9, 8'h77, 0, 0);        // R4 other address
        step("R4", 0, 0, 1, 2, 8'h20, 0, 0);        // R4 low byte jump -> 0120h
        run("R4", 2, 0);
        step("R5", 1, 16'h0300, 1, 2, 8'h55, 0, 0); // R5 branch wins
        run("R5", 2, 0);
        step("R6", 0, 0, 0, 0, 0, 1, 0);            // R6 stall holds
        step("R6", 0, 0, 0, 0, 0, 1, 0);
        step("R6", 1, 16'h0500, 0, 0, 0, 1, 0);     // R6 redirect during stall
        run("R6", 2, 0);
        step("R7", 1, 16'hA000, 0, 0, 0, 0, 1);     // R7 high address aliases inside
        run("R7", 3, 1);
        step("R8", 1, 16'h0010, 0, 0, 0, 0, 2);     // R8 external only
        run("R8", 3, 2);
        step("R9", 1, 16'h1FFE, 0, 0, 0, 0, 3);     // R9 cross internal boundary
        run("R9", 4, 3);
        step("R9", 1, 16'h0100, 0, 0, 0, 0, 3);
        run("R9", 2, 3);
        step("R2", 1, 16'hFFFE, 0, 0, 0, 0, 2);     // R2 wrap FFFFh -> 0000h
        run("R2", 4, 2);
        run("R10", 2, 3);                           // R10 covered by strobe checks
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule